// File: doc/BRIEF.md
# In-Band Filter Rule Update Parser

This block sits on a 32-bit word stream of IP datagrams, in front of a two-entry packet filter. It watches each datagram for one signature: a fixed source IP address (default 0xC0A81E0D) and a fixed UDP destination port (default 0x0320). A datagram that carries the signature is a control datagram. Its payload holds new value and mask images for the filter entries. The block walks that payload into shadow registers. When the datagram ends with its end-of-frame strobe, the block copies the shadow images into the live rule outputs and raises a one-cycle commit pulse. A control datagram never reaches the output, whether or not it commits.

Every other datagram passes through unchanged. All words go through a short delay line, so that a datagram can still be withdrawn once its UDP destination port is known. The input marks three points in each datagram: the first IP header word (start strobe), the first UDP header word (datagram strobe) and the last word (end strobe). The IP header is five words. Those words and the first UDP header word arrive on consecutive cycles. Gaps in the valid signal are allowed only after that point.

Top module: `rule_update_parser`

## Requirements
- R1: A datagram is a control datagram when header word 3 (counting from 0 at the start-strobe word) equals CTL_SRC_IP, and bits 15:0 of the datagram-strobe word equal CTL_DST_PORT.
- R2: No word of a control datagram appears on the output. This holds for complete, truncated and zero-count control datagrams alike.
- R3: Every word of any other datagram appears on the output in order, with its data and strobes unchanged, exactly 6 clock edges after the edge that samples it.
- R4: The control payload starts with the second enabled word after the datagram-strobe word. Payload word 0 is the entry count. The words that follow come in groups of eight, one group per entry, entry 0 first. In each group, four value words come first and four mask words follow. Each set of four is: source IP, destination IP, ports, protocol.
- R5: In the ports word, bits 31:16 are the source port and bits 15:0 the destination port. In the protocol word only bits 31:24 count. Entry e occupies bits [e*104 +: 104] of rule_value and rule_mask. Within those 104 bits: 103:72 source IP, 71:40 destination IP, 39:24 source port, 23:8 destination port, 7:0 protocol.
- R6: Live rules change only when a control datagram's end strobe arrives after the last word that its count requires. A control datagram that ends earlier leaves the rules unchanged and gives no pulse.
- R7: A count of 0 changes nothing and gives no pulse. A count of 1 updates entry 0 only and leaves entry 1 unchanged.
- R8: A count above 2 updates entries 0 and 1 only. Words after the second entry's group are ignored.
- R9: On commit, commit_pulse is high for exactly one cycle. It rises on the second clock edge after the edge that samples the end-strobe word, in the same cycle as the new rule values.
- R10: After reset, out_valid and commit_pulse are low and both rule vectors are zero.
- R11: A datagram that matches only one of the two signature fields is forwarded normally and does not touch the rules.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word valid |
| in_sof | input | 1 | First IP header word |
| in_sod | input | 1 | First UDP header word |
| in_eof | input | 1 | Last word of the datagram |
| in_data | input | 32 | Input word |
| out_valid | output | 1 | Output word valid |
| out_sof | output | 1 | Forwarded start strobe |
| out_sod | output | 1 | Forwarded datagram strobe |
| out_eof | output | 1 | Forwarded end strobe |
| out_data | output | 32 | Forwarded word |
| rule_value | output | 208 | Live value images, entry e at [e*104 +: 104] |
| rule_mask | output | 208 | Live mask images, same layout |
| commit_pulse | output | 1 | One-cycle pulse per committed update |

## Verification
The bench sends near-miss datagrams that match only the source address or only the port. A detector that checks just one field would swallow these and corrupt the rules. A truncated control datagram catches a design that commits on any end strobe. Zero, one and five-entry counts expose missing count clipping: the pulse would fire for zero, entry 1 would be overwritten for a count of one, or the third group would land in a live entry. Payload gaps inside control datagrams, and cycle-exact scoreboard timestamps on forwarded words, catch a kill window that leaks header words or shifts the latency.

// File: rtl/rup_pkg.sv
package rup_pkg;
  localparam int WORD_W = 32;
  localparam int IMG_W = 104;
  localparam int GROUP_WORDS = 8;

  typedef struct packed {
    logic              valid;
    logic              sof;
    logic              sod;
    logic              eof;
    logic [WORD_W-1:0] data;
  } beat_t;

  typedef enum logic [1:0] {PS_IDLE, PS_SKIP, PS_PAY} pstate_e;
endpackage

// File: rtl/rup_delay.sv
module rup_delay
  import rup_pkg::*;
#(
  parameter int DEPTH = 6
) (
  input  logic  clk,
  input  logic  rst,
  input  beat_t in_b,
  input  logic  drop,
  input  logic  kill,
  output beat_t out_b
);
  beat_t stg [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      stg[0] <= '0;
    end else begin
      stg[0]       <= in_b;
      stg[0].valid <= in_b.valid & ~drop;
    end
  end

  for (genvar i = 1; i < DEPTH; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) begin
        stg[i] <= '0;
      end else begin
        stg[i]       <= stg[i-1];
        stg[i].valid <= stg[i-1].valid & ~kill;
      end
    end
  end

  assign out_b = stg[DEPTH-1];

  // R2: once a control datagram is recognised, its header words leave no trace
  a_r2_kill_clears: assert property (@(posedge clk) disable iff (rst)
    kill |=> !out_b.valid);
endmodule

// File: rtl/rup_parser.sv
module rup_parser
  import rup_pkg::*;
#(
  parameter int          NUM_ENTRIES  = 2,
  parameter logic [31:0] CTL_SRC_IP   = 32'hC0A8_1E0D,
  parameter logic [15:0] CTL_DST_PORT = 16'h0320,
  parameter int          HDR_WORDS    = 5,
  parameter int          SRC_WORD     = 3,
  localparam int         N_W          = $clog2(NUM_ENTRIES + 1)
) (
  input  logic  clk,
  input  logic  rst,
  input  beat_t in_b,
  output logic  ctl_hit,
  output logic  drop,
  output logic [NUM_ENTRIES-1:0][1:0][IMG_W-1:0] shadow,
  output logic  commit_req,
  output logic [N_W-1:0] n_commit
);
  localparam int SH_WORDS = GROUP_WORDS * NUM_ENTRIES;
  localparam int P_W = $clog2(SH_WORDS + 2);
  localparam int H_W = $clog2(HDR_WORDS + 2);
  localparam int E_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;

  pstate_e        st;
  logic [H_W-1:0] hdr_idx;
  logic           in_frame, src_ok;
  logic [P_W-1:0] p, need, k;
  logic [N_W-1:0] n_reg, n_now;
  logic [E_W-1:0] wr_e;
  logic           hdr_ok, done_ok;

  always_comb begin
    if (p == '0)
      n_now = (in_b.data >= 32'(NUM_ENTRIES)) ? N_W'(NUM_ENTRIES) : N_W'(in_b.data);
    else
      n_now = n_reg;
    need    = P_W'({n_now, 3'b000});
    hdr_ok  = in_frame && !in_b.sof && (hdr_idx == H_W'(HDR_WORDS));
    ctl_hit = in_b.valid && in_b.sod && hdr_ok && src_ok &&
              (in_b.data[15:0] == CTL_DST_PORT);
    drop    = ctl_hit || (in_b.valid && st != PS_IDLE);
    done_ok = in_b.valid && in_b.eof && st == PS_PAY && n_now != '0 && p >= need;
    k       = p - 1'b1;
    wr_e    = E_W'(k >> 3);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= PS_IDLE;
      hdr_idx <= '0;
      in_frame <= 1'b0;
      src_ok <= 1'b0;
      p <= '0;
      n_reg <= '0;
      shadow <= '0;
      commit_req <= 1'b0;
      n_commit <= '0;
    end else begin
      commit_req <= done_ok;
      if (done_ok) n_commit <= n_now;
      if (in_b.valid) begin
        if (in_b.sof) begin
          in_frame <= 1'b1;
          hdr_idx  <= H_W'(1);
          src_ok   <= 1'b0;
        end else if (in_frame) begin
          if (hdr_idx <= H_W'(HDR_WORDS)) hdr_idx <= hdr_idx + 1'b1;
          if (hdr_idx == H_W'(SRC_WORD)) src_ok <= (in_b.data == CTL_SRC_IP);
        end
        if (in_b.eof) in_frame <= 1'b0;
        unique case (st)
          PS_IDLE: if (ctl_hit && !in_b.eof) st <= PS_SKIP;
          PS_SKIP: begin
            p  <= '0;
            st <= in_b.eof ? PS_IDLE : PS_PAY;
          end
          PS_PAY: begin
            if (p == '0) n_reg <= n_now;
            if (p != '0 && p <= P_W'(SH_WORDS)) begin
              unique case (k[1:0])
                2'd0: shadow[wr_e][k[2]][103:72] <= in_b.data;
                2'd1: shadow[wr_e][k[2]][71:40]  <= in_b.data;
                2'd2: shadow[wr_e][k[2]][39:8]   <= in_b.data;
                default: shadow[wr_e][k[2]][7:0] <= in_b.data[31:24];
              endcase
            end
            if (p <= P_W'(SH_WORDS)) p <= p + 1'b1;
            if (in_b.eof) st <= PS_IDLE;
          end
          default: st <= PS_IDLE;
        endcase
      end
    end
  end

  // R9: a commit request always follows an end-strobe word
  a_r9_req_after_eof: assert property (@(posedge clk) disable iff (rst)
    commit_req |-> $past(in_b.valid && in_b.eof));
  // R7: a zero count never requests a commit
  a_r7_req_nonzero: assert property (@(posedge clk) disable iff (rst)
    commit_req |-> (n_commit != '0));
endmodule

// File: rtl/rup_rules.sv
module rup_rules
  import rup_pkg::*;
#(
  parameter int  NUM_ENTRIES = 2,
  localparam int N_W = $clog2(NUM_ENTRIES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic [NUM_ENTRIES-1:0][1:0][IMG_W-1:0] shadow,
  input  logic commit_req,
  input  logic [N_W-1:0] n_commit,
  output logic [NUM_ENTRIES*IMG_W-1:0] rule_value,
  output logic [NUM_ENTRIES*IMG_W-1:0] rule_mask,
  output logic commit_pulse
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rule_value   <= '0;
      rule_mask    <= '0;
      commit_pulse <= 1'b0;
    end else begin
      commit_pulse <= commit_req;
      for (int e = 0; e < NUM_ENTRIES; e++) begin
        if (commit_req && n_commit > N_W'(e)) begin
          rule_value[e*IMG_W +: IMG_W] <= shadow[e][0];
          rule_mask[e*IMG_W +: IMG_W]  <= shadow[e][1];
        end
      end
    end
  end

  // R6: live rules move only in the cycle after a commit request
  a_r6_rules_hold: assert property (@(posedge clk) disable iff (rst)
    !$past(commit_req) |-> ($stable(rule_value) && $stable(rule_mask)));
  // R9: the pulse lasts a single cycle
  a_r9_pulse_single: assert property (@(posedge clk) disable iff (rst)
    commit_pulse |=> !commit_pulse);
endmodule

// File: rtl/rule_update_parser.sv
module rule_update_parser
  import rup_pkg::*;
#(
  parameter int          NUM_ENTRIES  = 2,
  parameter logic [31:0] CTL_SRC_IP   = 32'hC0A8_1E0D,
  parameter logic [15:0] CTL_DST_PORT = 16'h0320,
  parameter int          HDR_WORDS    = 5,
  parameter int          SRC_WORD     = 3
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         in_valid,
  input  logic                         in_sof,
  input  logic                         in_sod,
  input  logic                         in_eof,
  input  logic [31:0]                  in_data,
  output logic                         out_valid,
  output logic                         out_sof,
  output logic                         out_sod,
  output logic                         out_eof,
  output logic [31:0]                  out_data,
  output logic [NUM_ENTRIES*104-1:0]   rule_value,
  output logic [NUM_ENTRIES*104-1:0]   rule_mask,
  output logic                         commit_pulse
);
  localparam int DEPTH = HDR_WORDS + 1;
  localparam int N_W = $clog2(NUM_ENTRIES + 1);

  beat_t in_b, out_b;
  logic ctl_hit, drop, commit_req;
  logic [N_W-1:0] n_commit;
  logic [NUM_ENTRIES-1:0][1:0][IMG_W-1:0] shadow;

  assign in_b = '{valid: in_valid, sof: in_sof & in_valid, sod: in_sod & in_valid,
                  eof: in_eof & in_valid, data: in_data};

  rup_parser #(
    .NUM_ENTRIES(NUM_ENTRIES), .CTL_SRC_IP(CTL_SRC_IP), .CTL_DST_PORT(CTL_DST_PORT),
    .HDR_WORDS(HDR_WORDS), .SRC_WORD(SRC_WORD)
  ) u_parser (
    .clk(clk), .rst(rst), .in_b(in_b), .ctl_hit(ctl_hit), .drop(drop),
    .shadow(shadow), .commit_req(commit_req), .n_commit(n_commit)
  );

  rup_delay #(.DEPTH(DEPTH)) u_delay (
    .clk(clk), .rst(rst), .in_b(in_b), .drop(drop), .kill(ctl_hit), .out_b(out_b)
  );

  rup_rules #(.NUM_ENTRIES(NUM_ENTRIES)) u_rules (
    .clk(clk), .rst(rst), .shadow(shadow), .commit_req(commit_req),
    .n_commit(n_commit), .rule_value(rule_value), .rule_mask(rule_mask),
    .commit_pulse(commit_pulse)
  );

  assign out_valid = out_b.valid;
  assign out_sof   = out_b.sof;
  assign out_sod   = out_b.sod;
  assign out_eof   = out_b.eof;
  assign out_data  = out_b.data;
endmodule

// File: tb/rule_update_parser_bench.sv
`timescale 1ns/1ps
module rule_update_parser_bench;
  localparam int NE = 2;
  localparam int IW = 104;
  localparam logic [31:0] CIP = 32'hC0A8_1E0D;
  localparam logic [15:0] CPORT = 16'h0320;

  logic clk = 1'b0, rst = 1'b1;
  logic in_valid = 0, in_sof = 0, in_sod = 0, in_eof = 0;
  logic [31:0] in_data = '0;
  logic out_valid, out_sof, out_sod, out_eof, commit_pulse;
  logic [31:0] out_data;
  logic [NE*IW-1:0] rule_value, rule_mask;

  rule_update_parser u_rule_update_parser (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof), .in_sod(in_sod),
    .in_eof(in_eof), .in_data(in_data), .out_valid(out_valid), .out_sof(out_sof),
    .out_sod(out_sod), .out_eof(out_eof), .out_data(out_data),
    .rule_value(rule_value), .rule_mask(rule_mask), .commit_pulse(commit_pulse)
  );

  always #2.5 clk = ~clk;

  int errors = 0, checks = 0, cyc = 0;
  bit finished = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {logic sof, sod, eof; logic [31:0] data; int due;} exp_t;
  exp_t q[$];
  logic [31:0] fw[$];
  logic [NE*IW-1:0] mv = '0, mm = '0;

  task automatic check(input bit ok, input string req, input string act, input string exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%s expected=%s", req, act, exp);
    end
  endtask

  // Scoreboard monitor: pops each forwarded word and checks content and cycle
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (q.size() == 0) begin
        check(1'b0, "R2", $sformatf("beat %h", out_data), "no beat");
      end else begin
        exp_t e;
        e = q.pop_front();
        check({out_sof, out_sod, out_eof, out_data} == {e.sof, e.sod, e.eof, e.data} &&
              cyc == e.due, "R3",
              $sformatf("%b%b%b %h @%0d", out_sof, out_sod, out_eof, out_data, cyc),
              $sformatf("%b%b%b %h @%0d", e.sof, e.sod, e.eof, e.data, e.due));
      end
    end
  end

  function automatic logic [IW-1:0] img(input logic [31:0] w0, w1, w2, w3);
    return {w0, w1, w2, w3[31:24]};
  endfunction

  task automatic mk_hdr(input logic [31:0] sip, input logic [15:0] dport);
    fw.delete();
    fw.push_back(32'h4500_0040); fw.push_back(32'h0001_0000);
    fw.push_back(32'h4011_0000); fw.push_back(sip);
    fw.push_back(32'h0A00_0001); fw.push_back({16'h1234, dport});
    fw.push_back(32'h0020_0000);
  endtask

  task automatic add_group(input int seed);
    for (int j = 0; j < 8; j++) fw.push_back(32'h1000_0000 * (j + 1) + 32'h0001_0101 * seed + j);
  endtask

  function automatic logic [IW-1:0] grp_img(input int seed, input int half);
    logic [31:0] w [4];
    for (int j = 0; j < 4; j++) w[j] = 32'h1000_0000 * (half*4 + j + 1) + 32'h0001_0101 * seed + half*4 + j;
    return img(w[0], w[1], w[2], w[3]);
  endfunction

  task automatic send(input bit fwd, input bit exp_pulse, input bit gaps, input string req);
    logic p1, p2, p3;
    for (int i = 0; i < fw.size(); i++) begin
      if (gaps && i >= 8 && i % 3 == 0) begin
        @(negedge clk); in_valid = 0; in_sof = 0; in_sod = 0; in_eof = 0;
      end
      @(negedge clk);
      in_valid = 1; in_sof = (i == 0); in_sod = (i == 5);
      in_eof = (i == fw.size() - 1); in_data = fw[i];
      if (fwd) q.push_back('{sof: in_sof, sod: in_sod, eof: in_eof, data: in_data, due: cyc + 6});
    end
    @(negedge clk); in_valid = 0; in_sof = 0; in_sod = 0; in_eof = 0; p1 = commit_pulse;
    @(negedge clk); p2 = commit_pulse;
    @(negedge clk); p3 = commit_pulse;
    check(!p1 && p2 == exp_pulse && !p3, req, $sformatf("pulse %b%b%b", p1, p2, p3),
          $sformatf("pulse 0%b0", exp_pulse));
    repeat (8) @(negedge clk);
  endtask

  task automatic check_rules(input string req);
    check(rule_value == mv, req, $sformatf("%h", rule_value), $sformatf("%h", mv));
    check(rule_mask == mm, req, $sformatf("%h", rule_mask), $sformatf("%h", mm));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R10: reset state
    check(!out_valid && !commit_pulse, "R10", $sformatf("%b%b", out_valid, commit_pulse), "00");
    check_rules("R10");
    rst = 0;

    // R3: ordinary datagram with payload gaps
    mk_hdr(32'h0A00_0009, 16'h0035);
    for (int j = 0; j < 6; j++) fw.push_back(32'hA5A5_0000 + j);
    send(1, 0, 1, "R3");

    // R1 R4 R5 R9: full control datagram, two entries, gaps in payload
    mk_hdr(CIP, CPORT); fw.push_back(32'd2); add_group(1); add_group(2);
    send(0, 1, 1, "R9");
    mv[0 +: IW] = grp_img(1, 0); mm[0 +: IW] = grp_img(1, 1);
    mv[IW +: IW] = grp_img(2, 0); mm[IW +: IW] = grp_img(2, 1);
    check_rules("R4 R5 R1");

    // R11: address mismatch, then port mismatch
    mk_hdr(CIP + 1, CPORT); fw.push_back(32'd2); add_group(7); add_group(8);
    send(1, 0, 0, "R11");
    check_rules("R11");
    mk_hdr(CIP, CPORT + 1); fw.push_back(32'd2); add_group(7); add_group(8);
    send(1, 0, 0, "R11");
    check_rules("R11");

    // R6 R2: truncated control datagram (second group short by four words)
    mk_hdr(CIP, CPORT); fw.push_back(32'd2); add_group(3);
    for (int j = 0; j < 4; j++) fw.push_back(32'hDEAD_0000 + j);
    send(0, 0, 0, "R6");
    check_rules("R6");

    // R7: zero count with trailing words
    mk_hdr(CIP, CPORT); fw.push_back(32'd0); add_group(4); add_group(5);
    send(0, 0, 0, "R7");
    check_rules("R7");

    // R7: count one touches entry 0 only
    mk_hdr(CIP, CPORT); fw.push_back(32'd1); add_group(6);
    send(0, 1, 0, "R7");
    mv[0 +: IW] = grp_img(6, 0); mm[0 +: IW] = grp_img(6, 1);
    check_rules("R7");

    // R8: count five, three groups sent, third ignored
    mk_hdr(CIP, CPORT); fw.push_back(32'd5); add_group(9); add_group(10); add_group(11);
    send(0, 1, 1, "R8");
    mv[0 +: IW] = grp_img(9, 0); mm[0 +: IW] = grp_img(9, 1);
    mv[IW +: IW] = grp_img(10, 0); mm[IW +: IW] = grp_img(10, 1);
    check_rules("R8");

    // R3: traffic still forwarded after control datagrams
    mk_hdr(32'h0A00_0003, 16'h0050);
    for (int j = 0; j < 3; j++) fw.push_back(32'h5A5A_0000 + j);
    send(1, 0, 0, "R3");
    check(q.size() == 0, "R3", $sformatf("%0d left", q.size()), "0 left");

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule